// File: doc/BRIEF.md
# Binary Convolution Engine Sequencer

This block is the control sequencer for a logic-in-memory binary convolution engine. A host drives four request lines: write an input-map word, write a kernel word, launch a computation, and read a result. The sequencer holds one of three states: loading, computing or results. In each state it decides which of these requests it takes, and it raises the matching internal enables toward the memory array and the compute counter. There is no idle state. Leaving reset, or starting a new load from the results state, always lands in the loading state. While the sequencer sits there, the compute counter is held cleared.

The XNOR/popcount datapath and the memory array sit outside this block. The length of a computation is modelled by a small counter inside the block. It finishes after `computeLen` cycles spent in the computing state, and a value of zero counts as one cycle. A request that arrives in a state that does not take it is dropped. It raises no enable and changes no state.

Top module: `binseq_top`

## Requirements
- R1: A synchronous active-high `rst` puts the sequencer in the loading state at the next clock edge. While `rst` is high, `memWrMap` and `memWrKer` stay low.
- R2: In the loading state `cntClear` is high. The state does not change for as long as `reqCompute` stays low.
- R3: `reqCompute` high in the loading state moves the sequencer to the computing state at the next edge. `computeEn` then stays high for exactly max(`computeLen`,1) cycles, after which the sequencer enters the results state.
- R4: `ready` is high exactly when the sequencer is in the results state. Exactly one of `cntClear`, `computeEn` and `ready` is high at any time after reset.
- R5: In the loading or results state, when `rst` and `reqCompute` are low, `memWrMap` follows `reqWrMap` and `memWrKer` follows `reqWrKer` in the same cycle. The two enables are independent, and both may be high at once.
- R6: Write requests in the computing state are ignored. No write enable is raised, and the state is unchanged.
- R7: `readEn` is high only when `reqRead` is high in the results state. In the loading and computing states a read request is ignored.
- R8: In the results state an accepted write moves the sequencer to the loading state at the next edge. `reqCompute` alone in the results state is ignored, and the sequencer stays in the results state.
- R9: While `reqCompute` is high, no write request is accepted in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqWrMap | input | 1 | Host requests an input-map write |
| reqWrKer | input | 1 | Host requests a kernel write |
| reqCompute | input | 1 | Host requests a computation launch |
| reqRead | input | 1 | Host requests a result read |
| computeLen | input | LEN_W | Cycles the computation counter runs (0 treated as 1) |
| ready | output | 1 | High in the results state |
| memWrMap | output | 1 | Input-map write enable toward memory |
| memWrKer | output | 1 | Kernel write enable toward memory |
| readEn | output | 1 | Result read enable toward memory |
| computeEn | output | 1 | High in the computing state |
| cntClear | output | 1 | Compute-counter clear, high in the loading state |

## Verification
The properties assume that every request input is a clean synchronous level, already brought into the clock domain, that holds steady between edges. They also assume that `computeLen` is not changed while a computation is running. The bench drives every input on the falling edge and changes `computeLen` only while the sequencer is in the loading state. It holds `reqCompute` until `ready` rises, just as a host waiting for completion would, so that the overlap of a held launch request with the results state is exercised.

// File: rtl/binseq_pkg.sv
package binseq_pkg;
  typedef enum logic [1:0] {
    ST_FILL = 2'd0,
    ST_COMP = 2'd1,
    ST_RES  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic cntClear;
    logic cntRun;
  } ctrlStrobe_t;
endpackage

// File: rtl/binseq_control.sv
module binseq_control
  import binseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqWrMap,
  input  logic        reqWrKer,
  input  logic        reqCompute,
  input  logic        reqRead,
  input  logic        cntDone,
  output ctrlStrobe_t strobe,
  output logic        ready,
  output logic        memWrMap,
  output logic        memWrKer,
  output logic        readEn,
  output logic        computeEn
);
  seqState_t state, stateNext;
  logic writeWindow;
  logic anyWrite;

  // writes are taken in loading/results, never under reset or a launch request
  assign writeWindow = (state == ST_FILL || state == ST_RES) && !rst && !reqCompute;
  assign memWrMap    = writeWindow && reqWrMap;
  assign memWrKer    = writeWindow && reqWrKer;
  assign anyWrite    = memWrMap || memWrKer;
  assign readEn      = (state == ST_RES) && reqRead;
  assign ready       = (state == ST_RES);
  assign computeEn   = (state == ST_COMP);

  assign strobe.cntClear = (state == ST_FILL);
  assign strobe.cntRun   = (state == ST_COMP);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_FILL: if (reqCompute) stateNext = ST_COMP;
      ST_COMP: if (cntDone)    stateNext = ST_RES;
      ST_RES:  if (anyWrite)   stateNext = ST_FILL;
      default:                 stateNext = ST_FILL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FILL;
    else     state <= stateNext;
  end
endmodule

// File: rtl/binseq_datapath.sv
module binseq_datapath
  import binseq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobe_t      strobe,
  input  logic [LEN_W-1:0] computeLen,
  output logic             cntDone
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] count;
  logic [LEN_W-1:0] lastIdx;

  assign lastIdx = (computeLen == '0) ? '0 : computeLen - ONE;
  assign cntDone = strobe.cntRun && (count == lastIdx);

  always_ff @(posedge clk) begin
    if (rst || strobe.cntClear) count <= '0;
    else if (strobe.cntRun)     count <= count + ONE;
  end
endmodule

// File: rtl/binseq_top.sv
module binseq_top
  import binseq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqWrMap,
  input  logic             reqWrKer,
  input  logic             reqCompute,
  input  logic             reqRead,
  input  logic [LEN_W-1:0] computeLen,
  output logic             ready,
  output logic             memWrMap,
  output logic             memWrKer,
  output logic             readEn,
  output logic             computeEn,
  output logic             cntClear
);
  ctrlStrobe_t strobe;
  logic        cntDone;

  binseq_control u_ctrl (
    .clk(clk), .rst(rst),
    .reqWrMap(reqWrMap), .reqWrKer(reqWrKer),
    .reqCompute(reqCompute), .reqRead(reqRead),
    .cntDone(cntDone), .strobe(strobe),
    .ready(ready), .memWrMap(memWrMap), .memWrKer(memWrKer),
    .readEn(readEn), .computeEn(computeEn)
  );

  binseq_datapath #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .computeLen(computeLen), .cntDone(cntDone)
  );

  assign cntClear = strobe.cntClear;
endmodule

// File: rtl/binseq_checker.sv
module binseq_checker (
  input logic clk,
  input logic rst,
  input logic reqWrMap,
  input logic reqWrKer,
  input logic reqCompute,
  input logic reqRead,
  input logic ready,
  input logic memWrMap,
  input logic memWrKer,
  input logic readEn,
  input logic computeEn,
  input logic cntClear
);
  a_r1_reset_to_fill: assert property (@(posedge clk) rst |=> cntClear);
  a_r1_no_write_in_reset: assert property (@(posedge clk) rst |-> !memWrMap && !memWrKer);
  a_r2_hold_fill: assert property (@(posedge clk) disable iff (rst)
    cntClear && !reqCompute |=> cntClear);
  a_r3_launch: assert property (@(posedge clk) disable iff (rst)
    cntClear && reqCompute |=> computeEn);
  a_r4_one_state: assert property (@(posedge clk) disable iff (rst)
    $onehot({cntClear, computeEn, ready}));
  a_r6_no_write_computing: assert property (@(posedge clk) disable iff (rst)
    computeEn && (reqWrMap || reqWrKer) |-> !memWrMap && !memWrKer ##1 !cntClear);
  a_r7_read_only_results: assert property (@(posedge clk) disable iff (rst)
    readEn |-> ready && reqRead);
  a_r8_results_exit: assert property (@(posedge clk) disable iff (rst)
    ready && (memWrMap || memWrKer) |=> cntClear);
  a_r8_results_hold: assert property (@(posedge clk) disable iff (rst)
    ready && !memWrMap && !memWrKer |=> ready);
  a_r9_launch_blocks_write: assert property (@(posedge clk)
    reqCompute |-> !memWrMap && !memWrKer);
endmodule

bind binseq_top binseq_checker u_chk (
  .clk(clk), .rst(rst), .reqWrMap(reqWrMap), .reqWrKer(reqWrKer),
  .reqCompute(reqCompute), .reqRead(reqRead), .ready(ready),
  .memWrMap(memWrMap), .memWrKer(memWrKer), .readEn(readEn),
  .computeEn(computeEn), .cntClear(cntClear)
);

// File: tb/binseq_top_test.sv
module binseq_top_test;
  localparam int LEN_W = 8;
  localparam int NVEC  = 16;
  // {rst,wrMap,wrKer,comp,rd} {expMap,expKer,expRead} {nextClear,nextComp,nextReady}
  localparam logic [10:0] VEC [NVEC] = '{
    11'b11000_000_100,  // R1 reset, write masked
    11'b00000_000_100,  // R2 stay loading
    11'b01000_100_100,  // R5 map write
    11'b00100_010_100,  // R5 kernel write
    11'b00001_000_100,  // R7 read ignored in loading
    11'b01010_000_010,  // R9 write blocked, R3 launch
    11'b01110_000_010,  // R6 write ignored while computing
    11'b00011_000_001,  // R7 read ignored computing, R3 done
    11'b01010_000_001,  // R9/R8 write blocked in results
    11'b00001_001_001,  // R7 read accepted
    11'b00100_010_100,  // R8 write leaves results
    11'b00010_000_010,  // R3 launch
    11'b00010_000_010,  // R3 counting
    11'b00000_000_001,  // R4 results
    11'b11000_000_100,  // R1 reset from results
    11'b01100_110_100   // R5 both writes
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqWrMap = 1'b0, reqWrKer = 1'b0, reqCompute = 1'b0, reqRead = 1'b0;
  logic [LEN_W-1:0] computeLen = LEN_W'(2);
  logic ready, memWrMap, memWrKer, readEn, computeEn, cntClear;
  int applied = 0;
  int errors  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  binseq_top #(.LEN_W(LEN_W)) uut (
    .clk(clk), .rst(rst), .reqWrMap(reqWrMap), .reqWrKer(reqWrKer),
    .reqCompute(reqCompute), .reqRead(reqRead), .computeLen(computeLen),
    .ready(ready), .memWrMap(memWrMap), .memWrKer(memWrKer), .readEn(readEn),
    .computeEn(computeEn), .cntClear(cntClear)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    applied++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic launch(input int len, input int expCycles, input string req);
    int n = 0;
    @(negedge clk);
    computeLen = LEN_W'(len);
    reqCompute = 1'b1;
    @(negedge clk);
    while (computeEn && n < 300) begin
      n++;
      @(negedge clk);
    end
    check(req, {cntClear, computeEn, ready}, 3'b001);
    check(req, 3'(n > 7 ? 7 : n), 3'(expCycles));
    reqCompute = 1'b0;
    reqWrMap = 1'b1;
    @(negedge clk);
    reqWrMap = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1", {cntClear, computeEn, ready}, 3'b100);
    rst = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      {rst, reqWrMap, reqWrKer, reqCompute, reqRead} = VEC[i][10:6];
      #2;
      check($sformatf("R5/R7/R9 vec%0d", i), {memWrMap, memWrKer, readEn}, VEC[i][5:3]);
      @(negedge clk);
      check($sformatf("R3/R4/R8 vec%0d", i), {cntClear, computeEn, ready}, VEC[i][2:0]);
    end
    {rst, reqWrMap, reqWrKer, reqCompute, reqRead} = '0;
    // R2 long hold in loading
    repeat (20) @(negedge clk);
    check("R2", {cntClear, computeEn, ready}, 3'b100);
    launch(5, 5, "R3 len5");
    launch(0, 1, "R3 len0");
    launch(1, 1, "R3 len1");
    // R1 reset in mid-computation
    computeLen = LEN_W'(6);
    reqCompute = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 in compute", {cntClear, computeEn, ready}, 3'b010);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    reqCompute = 1'b0;
    check("R1 mid", {cntClear, computeEn, ready}, 3'b100);
    // R8 compute alone in results ignored
    launch(3, 3, "R3 len3");
    @(negedge clk);
    reqCompute = 1'b1;
    computeLen = LEN_W'(2);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    reqCompute = 1'b0;
    @(negedge clk);
    reqCompute = 1'b1;
    @(negedge clk);
    reqCompute = 1'b0;
    check("R8", {cntClear, computeEn, ready}, 3'b001);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end
endmodule